// File: doc/BRIEF.md
# Signed Countdown Event Timer

This block is a per-core event timer that runs off a free-running 64-bit tick counter kept inside the block. Software sets a deadline in one of two ways. It can load a 32-bit relative countdown directly, or it can write a 64-bit absolute deadline. The block does not keep the absolute deadline. On the write it converts the value into the same 32-bit countdown. The countdown is treated as a signed two's-complement number, and every tick decrements it.

The event condition holds while the countdown is zero or negative. Two behaviours follow from this. Any absolute deadline that lies 2^31 or more ticks ahead fires at once. An event that is left unserviced disappears by itself once the countdown runs past its most negative value and wraps to a positive one. At a 50 MHz tick rate the largest usable forward delta, 2^31 − 1 ticks, is just under 43 seconds.

The interrupt output is a level. It is high while the timer is enabled, the event condition holds, and the interrupt is not masked.

Top module: `cntdn_timer`

## Requirements
- R1: After reset the tick counter, the countdown and both control bits are zero, and irq_o is low.
- R2: Each cycle with tick_i high and no countdown or deadline write, the countdown drops by exactly one. It continues below zero without stopping. With tick_i low and no such write, it holds its value.
- R3: The status bit (control bit 2) reads 1 exactly when the enable bit (control bit 0) is 1 and the countdown is zero or has bit 31 set.
- R4: A write to address 0 loads the low 32 bits of wr_data_i into the countdown. A loaded value with bit 31 set raises the event in the cycle right after the write.
- R5: A write to address 1 loads the countdown with the low 32 bits of (written deadline − counter value after that edge). A deadline exactly 2^31 ahead fires in the cycle right after the write.
- R6: For a deadline a small number of ticks N ahead, irq_o stays low for N−1 ticks and rises on the Nth tick, when the counter equals the deadline.
- R7: When the countdown decrements from 0x8000_0000 it wraps to 0x7FFF_FFFF. The status bit and irq_o then fall, and the pending event is lost.
- R8: irq_o equals enable AND status AND NOT mask (mask is control bit 1). Masking does not stop the countdown.
- R9: Reading address 1 returns the tick counter plus the sign-extended countdown.
- R10: Reading address 3 returns the tick counter, which rises by one per tick. A write to address 3 has no effect.
- R11: With the enable bit low the status bit reads 0, but the countdown still decrements on every tick.
- R12: Writes to address 2 set only the enable and mask bits. The status bit cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter-enable tick; advances the counter and the countdown |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 countdown, 1 deadline, 2 control, 3 counter (read-only) |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 64 | Combinational read data for rd_addr_i |
| irq_o | output | 1 | Level-sensitive timer interrupt |

## Verification
Every piece of state is a register that updates on the clock edge where the write or tick occurs. irq_o, the status bit and all read data follow from those registers combinationally. A write or tick applied before an edge is therefore visible from one time unit after that edge, with no further delay. The bench drives its inputs after a falling edge and samples one time unit after the next rising edge. It counts the ticks it has issued to predict the counter, the countdown and the deadline readback. The wrap case preloads the countdown near its most negative value, so the 2^31-tick run is reduced to a few ticks.

// File: rtl/cntdn_pkg.sv
package cntdn_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CDOWN = 2'd0,
    SEL_DLINE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
  localparam int CTL_W    = 3;
endpackage

// File: rtl/cntdn_sysctr.sv
module cntdn_sysctr #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/cntdn_down.sv
module cntdn_down #(
  parameter int CD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            ld_rel_i,
  input  logic            ld_abs_i,
  input  logic [CD_W-1:0] wr_val_i,
  input  logic [CD_W-1:0] cnt_nxt_lo_i,
  output logic [CD_W-1:0] cd_o,
  output logic            fire_o
);
  logic [CD_W-1:0] cd_q;
  logic [CD_W-1:0] cd_d;
  logic            cd_upd;

  always_comb begin
    cd_d = cd_q;
    if (ld_abs_i)      cd_d = wr_val_i - cnt_nxt_lo_i;
    else if (ld_rel_i) cd_d = wr_val_i;
    else if (tick_i)   cd_d = cd_q - {{(CD_W-1){1'b0}}, 1'b1};
  end

  assign cd_upd = ld_abs_i | ld_rel_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cd_q <= '0;
    else if (cd_upd) cd_q <= cd_d;
  end

  assign cd_o   = cd_q;
  assign fire_o = cd_q[CD_W-1] | (cd_q == '0);
endmodule

// File: rtl/cntdn_ctrl.sv
module cntdn_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] wr_bits_i,
  input  logic       fire_i,
  output logic       en_o,
  output logic       mask_o,
  output logic       stat_o,
  output logic       irq_o
);
  logic en_q, mask_q;
  logic en_d, mask_d;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    if (wr_i) begin
      en_d   = wr_bits_i[0];
      mask_d = wr_bits_i[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_i) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign stat_o = en_q & fire_i;
  assign irq_o  = stat_o & ~mask_q;
endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
  import cntdn_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int CD_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CD_W-1:0]  cd_q;
  logic [CNT_W-1:0] cd_sext;
  logic [CNT_W-1:0] cd_zext;
  logic             fire;
  logic             ctl_en, ctl_mask, ctl_stat;
  logic             wr_cd, wr_dl, wr_ctl;
  logic [CTL_W-1:0] ctl_rd;

  assign wr_cd  = wr_en_i && (wr_addr_i == SEL_CDOWN);
  assign wr_dl  = wr_en_i && (wr_addr_i == SEL_DLINE);
  assign wr_ctl = wr_en_i && (wr_addr_i == SEL_CTRL);

  cntdn_sysctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  cntdn_down #(.CD_W(CD_W)) u_down (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .ld_rel_i     (wr_cd),
    .ld_abs_i     (wr_dl),
    .wr_val_i     (wr_data_i[CD_W-1:0]),
    .cnt_nxt_lo_i (cnt_nxt[CD_W-1:0]),
    .cd_o         (cd_q),
    .fire_o       (fire)
  );

  cntdn_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_ctl),
    .wr_bits_i (wr_data_i[1:0]),
    .fire_i    (fire),
    .en_o      (ctl_en),
    .mask_o    (ctl_mask),
    .stat_o    (ctl_stat),
    .irq_o     (irq_o)
  );

  generate
    if (CNT_W > CD_W) begin : g_ext
      logic unused_hi;
      assign cd_sext   = {{(CNT_W-CD_W){cd_q[CD_W-1]}}, cd_q};
      assign cd_zext   = {{(CNT_W-CD_W){1'b0}}, cd_q};
      assign unused_hi = ^{wr_data_i[CNT_W-1:CD_W], cnt_nxt[CNT_W-1:CD_W]};
    end else begin : g_trunc
      assign cd_sext = cd_q[CNT_W-1:0];
      assign cd_zext = cd_q[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[CTL_EN]   = ctl_en;
    ctl_rd[CTL_MASK] = ctl_mask;
    ctl_rd[CTL_STAT] = ctl_stat;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      SEL_CDOWN: rd_data_o = cd_zext;
      SEL_DLINE: rd_data_o = cnt_q + cd_sext;
      SEL_CTRL:  rd_data_o = {{(CNT_W-CTL_W){1'b0}}, ctl_rd};
      default:   rd_data_o = cnt_q;
    endcase
  end
endmodule

// File: rtl/cntdn_timer_chk.sv
module cntdn_timer_chk
  import cntdn_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int CD_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CD_W-1:0]  cd,
  input logic             en,
  input logic             mask,
  input logic             irq_o
);
  localparam logic [CD_W-1:0] CD_ONE = {{(CD_W-1){1'b0}}, 1'b1};
  localparam logic [CD_W-1:0] CD_MIN = {1'b1, {(CD_W-1){1'b0}}};

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && tick_i) |=> (cd == $past(cd) - CD_ONE));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !tick_i) |=> $stable(cd));

  a_r5_deadline_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == SEL_DLINE) |=>
      (cd + cnt[CD_W-1:0] == $past(wr_data_i[CD_W-1:0])));

  a_r7_wrap_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && tick_i && cd == CD_MIN) |=> !irq_o);

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en && !mask));

  a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

bind cntdn_timer cntdn_timer_chk #(.CNT_W(CNT_W), .CD_W(CD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .cnt       (cnt_q),
  .cd        (cd_q),
  .en        (ctl_en),
  .mask      (ctl_mask),
  .irq_o     (irq_o)
);

// File: tb/cntdn_timer_bench.sv
`timescale 1ns/1ps
module cntdn_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [1:0]  wr_addr_i;
  logic [63:0] wr_data_i;
  logic [1:0]  rd_addr_i;
  logic [63:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [63:0] exp_cnt = 64'd0;

  cntdn_timer u_cntdn_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  // one clock: drive after falling edge, return 1 ns after the rising edge
  task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    tick_i = t; wr_en_i = w; wr_addr_i = a; wr_data_i = d;
    @(posedge clk);
    #1;
    tick_i = 1'b0; wr_en_i = 1'b0;
    if (t) exp_cnt++;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
    rd(2'd0, v); chk("R1 countdown", v, 64'd0);
    rd(2'd3, v); chk("R1 counter", v, 64'd0);
    rd(2'd2, v); chk("R1 R3 control", v, 64'd0);
  endtask

  task automatic t_decrement;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 2'd0, 64'hABCD_0000_0000_0005);
    rd(2'd0, v); chk("R4 countdown load", v, 64'd5);
    cyc(1'b0, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R2 hold without tick", v, 64'd5);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R2 R11 decrement", v, 64'd2);
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R2 below zero", v, 64'h0000_0000_FFFF_FFFB);
    rd(2'd2, v); chk("R11 status low when disabled", v, 64'd0);
    chk("R11 irq low", {63'd0, irq_o}, 64'd0);
    rd(2'd3, v); chk("R10 counter", v, exp_cnt);
  endtask

  task automatic t_big_delta;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 2'd2, 64'd1);
    cyc(1'b0, 1'b1, 2'd1, exp_cnt + 64'h8000_0000);
    rd(2'd0, v); chk("R5 countdown from deadline", v, 64'h8000_0000);
    chk("R5 delta 2^31 fires at once", {63'd0, irq_o}, 64'd1);
    rd(2'd2, v); chk("R3 status set", v, 64'd5);
    cyc(1'b0, 1'b1, 2'd2, 64'd3);
    chk("R8 masked irq", {63'd0, irq_o}, 64'd0);
    rd(2'd2, v); chk("R8 status visible while masked", v, 64'd7);
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R8 countdown runs while masked", v, 64'h7FFF_FFFF);
    cyc(1'b0, 1'b1, 2'd2, 64'd1);
  endtask

  task automatic t_small_delta;
    logic [63:0] v;
    logic [63:0] dl;
    dl = exp_cnt + 64'd4;
    cyc(1'b0, 1'b1, 2'd1, dl);
    chk("R6 not yet", {63'd0, irq_o}, 64'd0);
    for (int i = 1; i < 4; i++) begin
      cyc(1'b1, 1'b0, 2'd0, 64'd0);
      chk("R6 before expiry", {63'd0, irq_o}, 64'd0);
      rd(2'd1, v); chk("R9 deadline readback", v, dl);
    end
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    chk("R6 fires at expiry", {63'd0, irq_o}, 64'd1);
    rd(2'd3, v); chk("R6 counter equals deadline", v, dl);
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    chk("R6 stays high after expiry", {63'd0, irq_o}, 64'd1);
    rd(2'd1, v); chk("R9 readback past expiry", v, dl);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 2'd0, 64'h8000_0002);
    chk("R4 negative load fires", {63'd0, irq_o}, 64'd1);
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R7 at most negative", v, 64'h8000_0000);
    chk("R7 still firing", {63'd0, irq_o}, 64'd1);
    cyc(1'b1, 1'b0, 2'd0, 64'd0);
    rd(2'd0, v); chk("R7 wrapped value", v, 64'h7FFF_FFFF);
    chk("R7 irq lost", {63'd0, irq_o}, 64'd0);
    rd(2'd2, v); chk("R7 status lost", v, 64'd1);
  endtask

  task automatic t_readonly;
    logic [63:0] v;
    cyc(1'b0, 1'b1, 2'd3, 64'h1234_5678_9ABC_DEF0);
    rd(2'd3, v); chk("R10 counter write ignored", v, exp_cnt);
    cyc(1'b0, 1'b1, 2'd0, 64'd0);
    cyc(1'b0, 1'b1, 2'd2, 64'd4);
    rd(2'd2, v); chk("R12 status not writable", v, 64'd0);
    chk("R12 irq low", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
    wr_addr_i = 2'd0; wr_data_i = 64'd0; rd_addr_i = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_decrement();
    t_big_delta();
    t_small_delta();
    t_wrap();
    t_readonly();
    finish_run();
  end
endmodule